// File: doc/BRIEF.md
# Prescaled 16-bit timer/counter

This block is a 16-bit up-counter. It counts ticks from one of four sources that are chosen at run time: the system clock, the system clock divided by four, a slow internal oscillator tick, or rising edges on an external pin. The chosen ticks pass through a prescaler with a ratio of 1, 2, 4 or 8. Each prescaled tick then either reaches the counter in the same cycle or goes through a two-flop resynchronizer that delays it by two cycles. Every source is handled as a one-cycle enable pulse in the system clock domain, so the whole block runs on a single clock.

The counter advances only while the module enable and the gate enable are both high. Software reaches the count one byte at a time. A write to either byte also restarts the prescaler. When the count rolls over from 0xFFFF to 0x0000, a sticky overflow flag is set. The flag clears only when a one is written to the clear input. If a rollover and a clear arrive in the same cycle, the rollover wins.

Top module: `pst_timer16`

## Requirements
- R1: After reset the count is 0x0000, the overflow flag is 0 and both read bytes return 0x00.
- R2: With source select 2'b01 (system clock), ratio select 2'b00 and `async_mode`=1, the count rises by exactly one on every clock edge while both enables are high.
- R3: With source select 2'b00, the source ticks once every 4 system clock cycles, so a window of 4k cycles at ratio 1 adds exactly k counts.
- R4: Source select 2'b10 counts one per cycle in which `lfo_tick` is high. Source select 2'b11 counts one per low-to-high transition of `ext_clk`, and a held high level does not count again.
- R5: A ratio select value n (2 bits) gives one count per 2^n source ticks, measured from a cleared prescaler.
- R6: With `async_mode`=0, the first count from a tick arrives two cycles later than with `async_mode`=1.
- R7: While `enable`=0 or `gate_en`=0, the count does not change.
- R8: A write with `wr_hi`=1 loads the high byte and a write with `wr_hi`=0 loads the low byte. In that cycle the write takes the place of any count. The write also clears the prescaler.
- R9: A count from 0xFFFF gives 0x0000 and sets `ovf_flag` on the same edge.
- R10: `ovf_flag` stays set until a cycle with `ovf_clr`=1. If a rollover happens in the same cycle as `ovf_clr`=1, the flag stays set.
- R11: `rd_data` shows the high byte when `rd_hi`=1 and the low byte when `rd_hi`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable |
| gate_en | input | 1 | Count enable from the gate unit |
| clk_sel | input | 2 | Source: 00 sys/4, 01 sys, 10 slow tick, 11 pin |
| pre_sel | input | 2 | Prescale ratio 2^pre_sel |
| async_mode | input | 1 | 1 bypasses the resynchronizer |
| lfo_tick | input | 1 | Slow oscillator tick pulse |
| ext_clk | input | 1 | External clock pin level |
| wr_en | input | 1 | Byte write strobe |
| wr_hi | input | 1 | Write byte select, 1 = high |
| wr_data | input | 8 | Write data |
| rd_hi | input | 1 | Read byte select, 1 = high |
| rd_data | output | 8 | Selected count byte |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a divide-by-4 source, a 2-bit ratio select and two resynchronizer stages. Because the largest ratio is 8, windows of 64 cycles exercise every source-and-ratio pair with exact expected counts. Preloading through the byte writes makes the 0xFFFF rollover reachable within a few cycles. With two resynchronizer stages, the latency difference between the two modes can be sampled cycle by cycle.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic [1:0] {
    SRC_SYS_DIV = 2'b00,
    SRC_SYS     = 2'b01,
    SRC_SLOW    = 2'b10,
    SRC_PIN     = 2'b11
  } src_e;
endpackage

// File: rtl/pst_source.sv
module pst_source #(
  parameter int SYS_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       lfo_tick,
  input  logic       ext_clk,
  output logic       src_pulse
);
  import pst_pkg::*;
  localparam int DIV_W = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SYS_DIV - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             pin_q;
  logic             div_pulse, pin_pulse;

  always_comb begin
    div_pulse = (div_q == DIV_LAST);
    div_d     = div_pulse ? '0 : div_q + DIV_W'(1);
    pin_pulse = ext_clk & ~pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pin_q <= 1'b0;
    end else begin
      div_q <= div_d;
      pin_q <= ext_clk;
    end
  end

  always_comb begin
    unique case (src_e'(sel))
      SRC_SYS_DIV: src_pulse = div_pulse;
      SRC_SYS:     src_pulse = 1'b1;
      SRC_SLOW:    src_pulse = lfo_tick;
      SRC_PIN:     src_pulse = pin_pulse;
      default:     src_pulse = 1'b0;
    endcase
  end
endmodule

// File: rtl/pst_prescaler.sv
module pst_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic             src_pulse,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             out_pulse
);
  localparam int PCNT_W = (1 << SEL_W) - 1;

  logic [PCNT_W-1:0] pcnt_q, pcnt_d, mask;
  logic              step;

  always_comb begin
    for (int i = 0; i < PCNT_W; i++) begin
      mask[i] = (i < int'(ratio_sel));
    end
    step      = run & src_pulse;
    out_pulse = step & ((pcnt_q & mask) == mask);
    if (clear) begin
      pcnt_d = '0;
    end else if (step) begin
      pcnt_d = out_pulse ? '0 : ((pcnt_q + PCNT_W'(1)) & mask);
    end else begin
      pcnt_d = pcnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/pst_sync.sv
module pst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bypass,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q, pipe_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign pipe_d[g] = d;
    end else begin : g_next
      assign pipe_d[g] = pipe_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q = bypass ? d : pipe_q[STAGES-1];
endmodule

// File: rtl/pst_counter.sv
module pst_counter #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc,
  input  logic                wr_en,
  input  logic                wr_hi,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                ovf_clr,
  output logic [2*BYTE_W-1:0] cnt_q,
  output logic                ovf_flag
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] cnt_d;
  logic             flag_q, flag_d, wrap;

  always_comb begin
    wrap = inc & ~wr_en & (cnt_q == {CNT_W{1'b1}});
    if (wr_en) begin
      cnt_d = wr_hi ? {wr_data, cnt_q[BYTE_W-1:0]} : {cnt_q[CNT_W-1:BYTE_W], wr_data};
    end else if (inc) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      cnt_d = cnt_q;
    end
    flag_d = wrap | (flag_q & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign ovf_flag = flag_q;
endmodule

// File: rtl/pst_timer16.sv
module pst_timer16 #(
  parameter int BYTE_W      = 8,
  parameter int SYS_DIV     = 4,
  parameter int PS_SEL_W    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                gate_en,
  input  logic [1:0]          clk_sel,
  input  logic [PS_SEL_W-1:0] pre_sel,
  input  logic                async_mode,
  input  logic                lfo_tick,
  input  logic                ext_clk,
  input  logic                wr_en,
  input  logic                wr_hi,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                rd_hi,
  output logic [BYTE_W-1:0]   rd_data,
  input  logic                ovf_clr,
  output logic                ovf_flag
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             src_pulse, pre_pulse, tick, inc;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  pst_source #(.SYS_DIV(SYS_DIV)) u_src (
    .clk(clk), .rst_n(rst_sync_n), .sel(clk_sel), .lfo_tick(lfo_tick),
    .ext_clk(ext_clk), .src_pulse(src_pulse)
  );

  pst_prescaler #(.SEL_W(PS_SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .run(enable), .clear(wr_en),
    .src_pulse(src_pulse), .ratio_sel(pre_sel), .out_pulse(pre_pulse)
  );

  pst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .bypass(async_mode), .d(pre_pulse), .q(tick)
  );

  assign inc = tick & enable & gate_en;

  pst_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .inc(inc), .wr_en(wr_en), .wr_hi(wr_hi),
    .wr_data(wr_data), .ovf_clr(ovf_clr), .cnt_q(cnt_q), .ovf_flag(ovf_flag)
  );

  assign rd_data = rd_hi ? cnt_q[CNT_W-1:BYTE_W] : cnt_q[BYTE_W-1:0];
endmodule

// File: rtl/pst_timer16_chk.sv
module pst_timer16_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic                gate_en,
  input logic                wr_en,
  input logic                wr_hi,
  input logic [BYTE_W-1:0]   wr_data,
  input logic                ovf_clr,
  input logic [2*BYTE_W-1:0] cnt,
  input logic                ovf_flag
);
  localparam int CNT_W = 2 * BYTE_W;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (!enable || !gate_en)) |=> $stable(cnt)); // R7

  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cnt != {CNT_W{1'b1}}) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1))); // R2

  AST_HIGH_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi) |=> (cnt[CNT_W-1:BYTE_W] == $past(wr_data))); // R8

  AST_LOW_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> (cnt[BYTE_W-1:0] == $past(wr_data))); // R8

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cnt == {CNT_W{1'b1}}) |=> (cnt == {CNT_W{1'b1}} || ovf_flag)); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R10

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && cnt != {CNT_W{1'b1}}) |=> !ovf_flag); // R10
endmodule

bind pst_timer16 pst_timer16_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .enable(enable), .gate_en(gate_en),
  .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data), .ovf_clr(ovf_clr),
  .cnt(cnt_q), .ovf_flag(ovf_flag)
);

// File: tb/pst_timer16_test.sv
module pst_timer16_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, gate_en = 1'b1, async_mode = 1'b1;
  logic [1:0] clk_sel = 2'b01, pre_sel = 2'b00;
  logic       lfo_tick = 1'b0, ext_clk = 1'b0;
  logic       wr_en = 1'b0, wr_hi = 1'b0, rd_hi = 1'b0, ovf_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       ovf_flag;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;
  logic [15:0] v;

  always #4 clk = ~clk;

  pst_timer16 uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .gate_en(gate_en),
    .clk_sel(clk_sel), .pre_sel(pre_sel), .async_mode(async_mode),
    .lfo_tick(lfo_tick), .ext_clk(ext_clk), .wr_en(wr_en), .wr_hi(wr_hi),
    .wr_data(wr_data), .rd_hi(rd_hi), .rd_data(rd_data), .ovf_clr(ovf_clr),
    .ovf_flag(ovf_flag)
  );

  // {sel, pre, gate, cycles, expected}
  localparam logic [20:0] VEC [0:8] = '{
    {2'd1, 2'd0, 1'b1, 8'd20, 8'd20},
    {2'd1, 2'd1, 1'b1, 8'd20, 8'd10},
    {2'd1, 2'd2, 1'b1, 8'd20, 8'd5},
    {2'd1, 2'd3, 1'b1, 8'd24, 8'd3},
    {2'd0, 2'd0, 1'b1, 8'd40, 8'd10},
    {2'd0, 2'd1, 1'b1, 8'd40, 8'd5},
    {2'd0, 2'd3, 1'b1, 8'd64, 8'd2},
    {2'd1, 2'd0, 1'b0, 8'd20, 8'd0},
    {2'd0, 2'd2, 1'b0, 8'd32, 8'd0}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_byte(input logic hi, input logic [7:0] d);
    wr_en = 1'b1; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load16(input logic [15:0] d);
    write_byte(1'b1, d[15:8]);
    write_byte(1'b0, d[7:0]);
  endtask

  task automatic read16(output logic [15:0] r);
    rd_hi = 1'b1; #1; r[15:8] = rd_data;
    rd_hi = 1'b0; #1; r[7:0] = rd_data;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    read16(v);
    check("R1 count after reset", v, 16'h0000);
    check("R1 flag after reset", {15'd0, ovf_flag}, 16'd0);

    // Table walk: R2 R3 R5 R7
    for (int i = 0; i < 9; i++) begin
      enable = 1'b0;
      clk_sel = VEC[i][20:19]; pre_sel = VEC[i][18:17]; gate_en = VEC[i][16];
      async_mode = 1'b1;
      load16(16'h0000);
      enable = 1'b1;
      step(int'(VEC[i][15:8]));
      enable = 1'b0;
      read16(v);
      check($sformatf("R2_R3_R5_R7 vector %0d", i), v, {8'h00, VEC[i][7:0]});
    end
    gate_en = 1'b1;

    // R4 slow tick source
    clk_sel = 2'b10; pre_sel = 2'b00; load16(16'h0000); enable = 1'b1;
    for (int i = 0; i < 5; i++) begin
      lfo_tick = 1'b1; step(1); lfo_tick = 1'b0; step(3);
    end
    enable = 1'b0; read16(v);
    check("R4 slow tick count", v, 16'd5);

    // R4 pin edges
    clk_sel = 2'b11; load16(16'h0000); enable = 1'b1;
    for (int i = 0; i < 6; i++) begin
      ext_clk = 1'b1; step(3); ext_clk = 1'b0; step(2);
    end
    enable = 1'b0; read16(v);
    check("R4 pin edge count", v, 16'd6);

    // R7 module enable low holds the value
    clk_sel = 2'b01; load16(16'h1234); step(10); read16(v);
    check("R7 hold while disabled", v, 16'h1234);

    // R6 resynchronized path latency
    async_mode = 1'b0; load16(16'h0000); enable = 1'b1;
    step(2); read16(v);
    check("R6 no count after two edges", v, 16'd0);
    step(1); read16(v);
    check("R6 first count after three edges", v, 16'd1);
    enable = 1'b0; async_mode = 1'b1; step(3);

    // R8 write overrides a count in the same cycle
    load16(16'h0000); enable = 1'b1; step(3);
    write_byte(1'b0, 8'h55); read16(v);
    check("R8 write wins over count", v, 16'h0055);
    step(1); read16(v);
    check("R8 counting resumes", v, 16'h0056);
    enable = 1'b0;

    // R8 write clears the prescaler
    pre_sel = 2'b10; load16(16'h0000); enable = 1'b1; step(2);
    write_byte(1'b0, 8'h00); step(3); read16(v);
    check("R8 prescaler restarted", v, 16'd0);
    step(1); read16(v);
    check("R8 prescaler full period", v, 16'd1);
    enable = 1'b0; pre_sel = 2'b00;

    // R9 rollover and R10 stickiness
    load16(16'hFFFE); enable = 1'b1; step(1); read16(v);
    check("R9 reaches FFFF", v, 16'hFFFF);
    check("R9 flag not yet set", {15'd0, ovf_flag}, 16'd0);
    step(1); enable = 1'b0; read16(v);
    check("R9 wraps to zero", v, 16'h0000);
    check("R9 flag set on wrap", {15'd0, ovf_flag}, 16'd1);
    step(4);
    check("R10 flag sticky", {15'd0, ovf_flag}, 16'd1);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    check("R10 flag cleared", {15'd0, ovf_flag}, 16'd0);

    // R10 set beats clear
    load16(16'hFFFF); enable = 1'b1; ovf_clr = 1'b1; step(1);
    ovf_clr = 1'b0; enable = 1'b0;
    check("R10 set wins over clear", {15'd0, ovf_flag}, 16'd1);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;

    // R11 byte select on reads
    load16(16'hA53C);
    rd_hi = 1'b1; #1; check("R11 high byte", {8'h00, rd_data}, 16'h00A5);
    rd_hi = 1'b0; #1; check("R11 low byte", {8'h00, rd_data}, 16'h003C);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule